// File: doc/BRIEF.md
# Protection Region Bounds Decoder

This block turns the raw configuration of a set of memory protection entries into explicit byte ranges. Every entry has an 8-bit configuration byte and a 32-bit address register that holds physical address bits 33:2. For each entry the block produces an inclusive start and end byte address, 34 bits wide. All entries are decoded side by side in pure combinational logic, so a downstream access checker can compare an address against every range in the same cycle.

A two-bit match-mode field in each configuration byte picks one of four ways of reading the address register. The first mode disables the entry. The second uses this entry's register and the one below it as a top-of-range pair. The third describes a naturally aligned four-byte word. The fourth describes a naturally aligned power-of-two region whose size is held in the run of low-order ones of the register. The block also reports which entries take part in matching and how many of them do.

Top module: `pmp_region_decoder`

## Requirements
- R1: When the match-mode field is 0 (disabled), the entry's start is 0 and its end is all ones (34 bits), and the entry is reported inactive.
- R2: When the match-mode field is 1 (top-of-range), the start is the address register of the entry one index lower, shifted left by 2. The end is this entry's register shifted left by 2, minus 1, taken modulo 2^34, so a zero register gives an end of all ones.
- R3: Entry 0 in top-of-range mode takes 0 as the lower register, so its start is 0.
- R4: When the match-mode field is 2 (four-byte word), the start is the register shifted left by 2 and the end is the start plus 3.
- R5: When the match-mode field is 3 (power-of-two region) and t is the number of consecutive ones counted from bit 0 of the register, the region covers 2^(t+3) bytes. Its start is the register with its low t bits cleared, shifted left by 2.
- R6: A register of all ones in power-of-two mode decodes to start 0 and end all ones.
- R7: The match-mode field sits in configuration bits 4:3. Bit i of activeMask is 1 exactly when entry i's field is not 0.
- R8: activeCount equals the number of entries whose match-mode field is not 0.
- R9: Configuration bits 7:5 and 2:0 have no effect on any start, end, activeMask or activeCount output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cfgFlat | input | NUM_ENTRIES*8 (64) | Configuration bytes; entry i occupies bits 8i+7:8i |
| addrFlat | input | NUM_ENTRIES*ADDR_REG_W (256) | Address registers (byte address bits 33:2); entry i occupies bits 32i+31:32i |
| startFlat | output | NUM_ENTRIES*PA_W (272) | Inclusive start byte address per entry, entry i at bits 34i+33:34i |
| endFlat | output | NUM_ENTRIES*PA_W (272) | Inclusive end byte address per entry, same packing as startFlat |
| activeMask | output | NUM_ENTRIES (8) | One bit per entry whose match mode is not disabled |
| activeCount | output | clog2(NUM_ENTRIES+1) (4) | Number of entries that are not disabled |

## Verification
The bench builds the block with its defaults: eight entries of 32-bit address registers, which gives 34-bit byte bounds. This width covers the full-width cases. These are a power-of-two register of 0x7FFFFFFF that spans the whole 2^34-byte space, the all-ones special case, a top-of-range end that wraps when the register is zero, and a four-byte word at the highest aligned address. Eight entries are enough to chain top-of-range entries from entry 0 upward and to mix all four modes in one input pattern, while the count output runs between 0 and 8.

// File: rtl/prd_pkg.sv
package prd_pkg;

  localparam int CFG_W     = 8;
  localparam int MODE_LSB  = 3;
  localparam int MODE_W    = 2;

  typedef enum logic [MODE_W-1:0] {
    MATCH_OFF   = 2'd0,
    MATCH_TOR   = 2'd1,
    MATCH_NA4   = 2'd2,
    MATCH_NAPOT = 2'd3
  } matchMode_e;

  // Strobes from control to datapath, one set per entry
  typedef struct packed {
    logic useTor;
    logic useWord;
    logic usePow2;
    logic pow2All;
  } boundSel_t;

endpackage

// File: rtl/prd_mode_ctrl.sv
module prd_mode_ctrl #(
  parameter int NUM_ENTRIES = 8,
  parameter int ADDR_REG_W  = 32
) (
  input  logic [NUM_ENTRIES-1:0][prd_pkg::CFG_W-1:0] cfgArr,
  input  logic [NUM_ENTRIES-1:0][ADDR_REG_W-1:0]     addrArr,
  output prd_pkg::boundSel_t [NUM_ENTRIES-1:0]        selArr,
  output logic [NUM_ENTRIES-1:0]                      activeMask,
  output logic [$clog2(NUM_ENTRIES+1)-1:0]            activeCount
);
  import prd_pkg::*;

  localparam int CNT_W = $clog2(NUM_ENTRIES + 1);

  for (genvar i = 0; i < NUM_ENTRIES; i++) begin : gEntry
    matchMode_e modeSel;
    assign modeSel = matchMode_e'(cfgArr[i][MODE_LSB +: MODE_W]);

    always_comb begin
      selArr[i] = '0;
      unique case (modeSel)
        MATCH_TOR:   selArr[i].useTor  = 1'b1;
        MATCH_NA4:   selArr[i].useWord = 1'b1;
        MATCH_NAPOT: begin
          selArr[i].usePow2 = 1'b1;
          selArr[i].pow2All = &addrArr[i];
        end
        default:     selArr[i] = '0;
      endcase
    end

    assign activeMask[i] = (modeSel != MATCH_OFF);
  end

  always_comb begin
    activeCount = '0;
    for (int k = 0; k < NUM_ENTRIES; k++) begin
      activeCount = activeCount + CNT_W'(activeMask[k]);
    end
  end

endmodule

// File: rtl/prd_ones_count.sv
module prd_ones_count #(
  parameter int VALUE_W = 32
) (
  input  logic [VALUE_W-1:0]           valueIn,
  output logic [$clog2(VALUE_W+1)-1:0] onesRun
);
  localparam int RUN_W = $clog2(VALUE_W + 1);

  // Priority encoder over the inverted value: lowest zero bit wins
  logic [VALUE_W-1:0] zeroBits;
  assign zeroBits = ~valueIn;

  always_comb begin
    onesRun = RUN_W'(VALUE_W);
    for (int b = VALUE_W - 1; b >= 0; b--) begin
      if (zeroBits[b]) onesRun = RUN_W'(b);
    end
  end

endmodule

// File: rtl/prd_bounds_path.sv
module prd_bounds_path #(
  parameter int NUM_ENTRIES = 8,
  parameter int ADDR_REG_W  = 32,
  parameter int PA_W        = ADDR_REG_W + 2
) (
  input  prd_pkg::boundSel_t [NUM_ENTRIES-1:0]    selArr,
  input  logic [NUM_ENTRIES-1:0][ADDR_REG_W-1:0]  addrArr,
  output logic [NUM_ENTRIES-1:0][PA_W-1:0]        startArr,
  output logic [NUM_ENTRIES-1:0][PA_W-1:0]        endArr
);
  localparam int RUN_W = $clog2(ADDR_REG_W + 1);
  localparam int SH_W  = RUN_W + 1;

  for (genvar i = 0; i < NUM_ENTRIES; i++) begin : gEntry
    logic [ADDR_REG_W-1:0] prevAddr;
    logic [PA_W-1:0]       byteAddr;
    logic [PA_W-1:0]       prevByte;
    logic [RUN_W-1:0]      onesRun;
    logic [SH_W-1:0]       sizeShift;
    logic [PA_W-1:0]       pow2Mask;

    if (i == 0) begin : gFirst
      assign prevAddr = '0;
    end else begin : gChain
      assign prevAddr = addrArr[i-1];
    end

    assign byteAddr = {addrArr[i], 2'b00};
    assign prevByte = {prevAddr, 2'b00};

    prd_ones_count #(.VALUE_W(ADDR_REG_W)) uOnes (
      .valueIn (addrArr[i]),
      .onesRun (onesRun)
    );

    assign sizeShift = SH_W'(onesRun) + SH_W'(3);
    assign pow2Mask  = ~({PA_W{1'b1}} << sizeShift);

    always_comb begin
      startArr[i] = '0;
      endArr[i]   = '1;
      if (selArr[i].useTor) begin
        startArr[i] = prevByte;
        endArr[i]   = byteAddr - PA_W'(1);
      end else if (selArr[i].useWord) begin
        startArr[i] = byteAddr;
        endArr[i]   = byteAddr + PA_W'(3);
      end else if (selArr[i].usePow2) begin
        if (selArr[i].pow2All) begin
          startArr[i] = '0;
          endArr[i]   = '1;
        end else begin
          startArr[i] = byteAddr & ~pow2Mask;
          endArr[i]   = byteAddr | pow2Mask;
        end
      end
    end
  end

endmodule

// File: rtl/pmp_region_decoder.sv
module pmp_region_decoder #(
  parameter int NUM_ENTRIES = 8,
  parameter int ADDR_REG_W  = 32,
  parameter int PA_W        = ADDR_REG_W + 2
) (
  input  logic [NUM_ENTRIES*8-1:0]           cfgFlat,
  input  logic [NUM_ENTRIES*ADDR_REG_W-1:0]  addrFlat,
  output logic [NUM_ENTRIES*PA_W-1:0]        startFlat,
  output logic [NUM_ENTRIES*PA_W-1:0]        endFlat,
  output logic [NUM_ENTRIES-1:0]             activeMask,
  output logic [$clog2(NUM_ENTRIES+1)-1:0]   activeCount
);
  logic [NUM_ENTRIES-1:0][prd_pkg::CFG_W-1:0] cfgArr;
  logic [NUM_ENTRIES-1:0][ADDR_REG_W-1:0]     addrArr;
  logic [NUM_ENTRIES-1:0][PA_W-1:0]           startArr;
  logic [NUM_ENTRIES-1:0][PA_W-1:0]           endArr;
  prd_pkg::boundSel_t [NUM_ENTRIES-1:0]       selArr;

  assign cfgArr    = cfgFlat;
  assign addrArr   = addrFlat;
  assign startFlat = startArr;
  assign endFlat   = endArr;

  prd_mode_ctrl #(
    .NUM_ENTRIES (NUM_ENTRIES),
    .ADDR_REG_W  (ADDR_REG_W)
  ) uCtrl (
    .cfgArr      (cfgArr),
    .addrArr     (addrArr),
    .selArr      (selArr),
    .activeMask  (activeMask),
    .activeCount (activeCount)
  );

  prd_bounds_path #(
    .NUM_ENTRIES (NUM_ENTRIES),
    .ADDR_REG_W  (ADDR_REG_W),
    .PA_W        (PA_W)
  ) uPath (
    .selArr   (selArr),
    .addrArr  (addrArr),
    .startArr (startArr),
    .endArr   (endArr)
  );

endmodule

// File: rtl/prd_checker.sv
module prd_checker #(
  parameter int NUM_ENTRIES = 8,
  parameter int ADDR_REG_W  = 32,
  parameter int PA_W        = ADDR_REG_W + 2
) (
  input logic [NUM_ENTRIES*8-1:0]          cfgFlat,
  input logic [NUM_ENTRIES*ADDR_REG_W-1:0] addrFlat,
  input logic [NUM_ENTRIES*PA_W-1:0]       startFlat,
  input logic [NUM_ENTRIES*PA_W-1:0]       endFlat,
  input logic [NUM_ENTRIES-1:0]            activeMask,
  input logic [$clog2(NUM_ENTRIES+1)-1:0]  activeCount
);
  localparam int CNT_W = $clog2(NUM_ENTRIES + 1);

  always_comb begin
    if (!$isunknown({cfgFlat, addrFlat})) begin
      for (int i = 0; i < NUM_ENTRIES; i++) begin
        if (cfgFlat[8*i+3 +: 2] == 2'd0) begin
          AST_OFF_FULL_RANGE: assert (startFlat[PA_W*i +: PA_W] == '0 &&
                                      endFlat[PA_W*i +: PA_W] == '1 &&
                                      !activeMask[i]); // R1
        end
        if (i > 0 && cfgFlat[8*i+3 +: 2] == 2'd1 && cfgFlat[8*(i-1)+3 +: 2] == 2'd1) begin
          AST_TOR_CHAIN_ABUTS: assert (startFlat[PA_W*i +: PA_W] ==
                                       endFlat[PA_W*(i-1) +: PA_W] + PA_W'(1)); // R2
        end
        if (i == 0 && cfgFlat[4:3] == 2'd1) begin
          AST_TOR_FIRST_ZERO: assert (startFlat[PA_W-1:0] == '0); // R3
        end
        if (cfgFlat[8*i+3 +: 2] == 2'd2) begin
          AST_WORD_SPAN: assert (endFlat[PA_W*i +: PA_W] - startFlat[PA_W*i +: PA_W] == PA_W'(3) &&
                                 startFlat[PA_W*i +: 2] == 2'b00); // R4
        end
        if (cfgFlat[8*i+3 +: 2] == 2'd3) begin
          AST_POW2_ALIGNED: assert ((((endFlat[PA_W*i +: PA_W] - startFlat[PA_W*i +: PA_W]) &
                                      (endFlat[PA_W*i +: PA_W] - startFlat[PA_W*i +: PA_W] + PA_W'(1))) == '0) &&
                                    ((startFlat[PA_W*i +: PA_W] &
                                      (endFlat[PA_W*i +: PA_W] - startFlat[PA_W*i +: PA_W])) == '0) &&
                                    (endFlat[PA_W*i +: 3] == 3'b111)); // R5
        end
        if (cfgFlat[8*i+3 +: 2] == 2'd3 && addrFlat[ADDR_REG_W*i +: ADDR_REG_W] == '1) begin
          AST_POW2_ALL_ONES: assert (startFlat[PA_W*i +: PA_W] == '0 &&
                                     endFlat[PA_W*i +: PA_W] == '1); // R6
        end
        AST_ACTIVE_BIT: assert (activeMask[i] == (cfgFlat[8*i+3 +: 2] != 2'd0)); // R7
      end
      AST_ACTIVE_COUNT: assert (activeCount == CNT_W'($countones(activeMask))); // R8
    end
  end

endmodule

bind pmp_region_decoder prd_checker #(
  .NUM_ENTRIES (NUM_ENTRIES),
  .ADDR_REG_W  (ADDR_REG_W),
  .PA_W        (PA_W)
) uChecker (
  .cfgFlat     (cfgFlat),
  .addrFlat    (addrFlat),
  .startFlat   (startFlat),
  .endFlat     (endFlat),
  .activeMask  (activeMask),
  .activeCount (activeCount)
);

// File: tb/pmp_region_decoder_test.sv
`timescale 1ns/1ps
module pmp_region_decoder_test;
  localparam int N  = 8;
  localparam int AW = 32;
  localparam int PW = AW + 2;
  localparam int CW = $clog2(N + 1);

  typedef struct {
    string          tag;
    int             idx;
    logic [PW-1:0]  expS;
    logic [PW-1:0]  expE;
  } item_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N*8-1:0]  cfgFlat  = '0;
  logic [N*AW-1:0] addrFlat = '0;
  logic [N*PW-1:0] startFlat;
  logic [N*PW-1:0] endFlat;
  logic [N-1:0]    activeMask;
  logic [CW-1:0]   activeCount;

  item_t sbq[$];
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  pmp_region_decoder #(.NUM_ENTRIES(N), .ADDR_REG_W(AW)) uut (
    .cfgFlat(cfgFlat), .addrFlat(addrFlat), .startFlat(startFlat),
    .endFlat(endFlat), .activeMask(activeMask), .activeCount(activeCount));

  // Independent reference computed from the requirements
  task automatic refBounds(input logic [7:0] cfg, input logic [AW-1:0] a,
                           input logic [AW-1:0] prev, input int idx,
                           output logic [PW-1:0] s, output logic [PW-1:0] e,
                           output string tag);
    logic [63:0] base;
    logic [63:0] size;
    int t;
    case (cfg[4:3])
      2'd0: begin s = '0; e = '1; tag = "R1"; end
      2'd1: begin
        s = PW'(64'(prev) * 4);
        e = PW'(64'(a) * 4 + 64'h3_FFFF_FFFF);
        tag = (idx == 0) ? "R3" : "R2";
      end
      2'd2: begin s = PW'(64'(a) * 4); e = PW'(64'(a) * 4 + 3); tag = "R4"; end
      default: begin
        if (a == '1) begin
          s = '0; e = '1; tag = "R6";
        end else begin
          t = 0;
          while (a[t]) t++;
          base = (64'(a) >> t) << t;
          size = 64'd1 << (t + 3);
          s = PW'(base * 4);
          e = PW'(base * 4 + size - 1);
          tag = "R5";
        end
      end
    endcase
  endtask

  task automatic driveVec(input logic [N-1:0][7:0] cfgs,
                          input logic [N-1:0][AW-1:0] addrs,
                          input string forceTag);
    item_t it;
    int nAct;
    logic [N-1:0] mask;
    @(posedge clk);
    cfgFlat  = cfgs;
    addrFlat = addrs;
    nAct = 0;
    mask = '0;
    for (int i = 0; i < N; i++) begin
      it.idx = i;
      refBounds(cfgs[i], addrs[i], (i == 0) ? '0 : addrs[i-1], i, it.expS, it.expE, it.tag);
      if (forceTag != "") it.tag = forceTag;
      sbq.push_back(it);
      if (cfgs[i][4:3] != 2'd0) begin
        nAct++;
        mask[i] = 1'b1;
      end
    end
    it.idx  = -1;
    it.tag  = (forceTag != "") ? forceTag : "R7 R8";
    it.expS = PW'(mask);
    it.expE = PW'(nAct);
    sbq.push_back(it);
  endtask

  // Monitor: compares away from the driving edge
  initial begin
    item_t it;
    forever begin
      @(negedge clk);
      while (sbq.size() > 0) begin
        it = sbq.pop_front();
        checks++;
        if (it.idx < 0) begin
          if (activeMask !== N'(it.expS) || activeCount !== CW'(it.expE)) begin
            errors++;
            $display("FAIL %s: mask/count actual %h/%0d expected %h/%0d",
                     it.tag, activeMask, activeCount, N'(it.expS), CW'(it.expE));
          end
        end else if (startFlat[PW*it.idx +: PW] !== it.expS ||
                     endFlat[PW*it.idx +: PW] !== it.expE) begin
          errors++;
          $display("FAIL %s: entry %0d actual %h..%h expected %h..%h", it.tag, it.idx,
                   startFlat[PW*it.idx +: PW], endFlat[PW*it.idx +: PW], it.expS, it.expE);
        end
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [N-1:0][7:0]  c;
    logic [N-1:0][AW-1:0] a;
    repeat (3) @(posedge clk);
    rst = 1'b0;

    // Idle state: everything disabled (R1, R7, R8)
    driveVec('0, '0, "");

    // Mixed modes: TOR chain from entry 0 (R3, R2), word (R4),
    // pow2 region (R5), all-ones (R6), 2^34 region, disabled with other bits, TOR wrap
    c = '0; a = '0;
    c[0] = 8'h08; a[0] = 32'h0000_0100;
    c[1] = 8'h08; a[1] = 32'h0000_0400;
    c[2] = 8'h10; a[2] = 32'h0000_1000;
    c[3] = 8'h18; a[3] = 32'h0000_2003;
    c[4] = 8'h18; a[4] = 32'hFFFF_FFFF;
    c[5] = 8'h18; a[5] = 32'h7FFF_FFFF;
    c[6] = 8'hE7; a[6] = 32'h1234_5678;
    c[7] = 8'h08; a[7] = 32'h0000_0000;
    driveVec(c, a, "");

    // R9: same addresses, unrelated cfg bits flipped; bounds and counts unchanged
    for (int i = 0; i < N; i++) c[i] = c[i] ^ 8'hE7;
    driveVec(c, a, "R9");

    // Word at top of space, pow2 with zero register (8 bytes), odd runs
    c = '0; a = '0;
    c[0] = 8'h10; a[0] = 32'hFFFF_FFFF;
    c[1] = 8'h18; a[1] = 32'h0000_0000;
    c[2] = 8'h18; a[2] = 32'h8000_0000;
    c[3] = 8'h18; a[3] = 32'hBFFF_FFFF;
    c[4] = 8'h08; a[4] = 32'hFFFF_FFFF;
    c[5] = 8'h18; a[5] = 32'h0000_00FF;
    c[6] = 8'h10; a[6] = 32'h0000_0000;
    c[7] = 8'h08; a[7] = 32'h0000_0001;
    driveVec(c, a, "");

    // All entries active in TOR mode (count reaches N)
    for (int i = 0; i < N; i++) begin
      c[i] = 8'h08;
      a[i] = 32'(i * 32'h100 + 32'h40);
    end
    driveVec(c, a, "");

    // Pseudo-random patterns across all modes
    for (int v = 0; v < 40; v++) begin
      for (int i = 0; i < N; i++) begin
        c[i] = 8'($urandom);
        a[i] = $urandom;
        if (v % 4 == 1) a[i] = a[i] | 32'h0000_0FFF;
      end
      driveVec(c, a, "");
    end

    while (sbq.size() > 0) @(posedge clk);
    repeat (2) @(posedge clk);
    finished = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule